// File: doc/BRIEF.md
# Latched Threshold Flag Interrupt Controller

This block watches the health of a four-channel optical module. Every cycle it takes five digitized attribute readings: laser bias current, module temperature, transmit optical power, receive optical power and supply voltage. It compares each reading against four programmable limits: a high alarm, a low alarm, a high warning and a low warning. It also takes two discrete status vectors, one bit per channel: loss of input signal and transmitter fault.

Any violation or status event sets a sticky flag. A flag stays set after its cause goes away and is cleared only when the host reads the flag register that holds it. An active-low interrupt line goes low while any flag is set whose mask bit is zero. The host then reads the flag registers to find out which channel and which kind of event raised it.

A simple register port stands in for the serial management bus. The host uses it to program the thresholds and masks and to read and clear the flags. Read data is registered and is valid in the cycle after the read strobe.

Top module: `fic_ctrl`

## Requirements
- R1: The high alarm flag (bit 0) and the high warning flag (bit 2) of an attribute are set when the unsigned reading is strictly greater than the matching threshold. A reading equal to the threshold sets nothing.
- R2: The low alarm flag (bit 1) and the low warning flag (bit 3) of an attribute are set when the unsigned reading is strictly less than the matching threshold. A reading equal to the threshold sets nothing. The flag register of attribute a is at address 0x02+a.
- R3: Loss-of-signal events set bit n of register 0x00, and transmitter-fault events set bit n of register 0x01, where n is the channel number.
- R4: Once set, a flag stays set after its cause clears, until it is read.
- R5: A read of a flag register returns the flag values from before the clear. The data appears on reg_rdata one cycle after the strobe. The read clears only the flags of that register. reg_rdata holds its value when no read is strobed.
- R6: If a flag's cause is active in the same cycle as the read that clears it, the flag stays set.
- R7: int_n goes low one cycle after an unmasked flag is set, or one cycle after the mask bit of a set flag is cleared.
- R8: int_n returns high one cycle after the last unmasked set flag is cleared by a read or becomes masked.
- R9: The mask register for flag register g is at address 0x10+g, with one bit per flag bit. A mask bit of 1 keeps that flag out of the interrupt but does not stop the flag from being set or read.
- R10: After reset, all flags, masks and low thresholds are zero, all high thresholds are all ones, and int_n is high.
- R11: Threshold k of attribute a is at address 0x20+4a+k, with k = 0 high alarm, 1 low alarm, 2 high warning, 3 low warning. Threshold and mask registers read back the value last written, and reading them changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| attr_rd | input | NUM_ATTR*DW | Attribute readings, attribute a in bits [a*DW +: DW] |
| ch_los | input | NUM_CH | Per-channel loss of input signal |
| ch_fault | input | NUM_CH | Per-channel transmitter fault |
| reg_addr | input | AW | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Registered read data |
| int_n | output | 1 | Active-low interrupt |

## Verification
The hardest case to create is a cause that is still active in the same cycle as the read that clears its flag. The bench holds a loss-of-signal input high across two back-to-back reads and expects the flag both times. It then drops the input and expects one last sticky read before the flag clears.

Mask timing is also hard to reach: a flag is set while masked, and the mask is then removed and restored. The bench watches int_n go low and then high again in exactly the following cycles, while the flag stays readable throughout.

// File: rtl/fic_pkg.sv
package fic_pkg;
  // register address bases
  localparam int FLAG_BASE = 'h00;
  localparam int MASK_BASE = 'h10;
  localparam int THR_BASE  = 'h20;

  // threshold kinds; also the flag bit positions inside an attribute flag register
  localparam int K_HA  = 0;
  localparam int K_LA  = 1;
  localparam int K_HW  = 2;
  localparam int K_LW  = 3;
  localparam int NKIND = 4;

  // flag register groups
  localparam int GRP_LOS   = 0;
  localparam int GRP_FLT   = 1;
  localparam int GRP_ATTR0 = 2;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic bit is_high_kind(input int k);
    return (k == K_HA) || (k == K_HW);
  endfunction
endpackage

// File: rtl/fic_thr_cmp.sv
module fic_thr_cmp
  import fic_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0]    reading,
  input  logic [DW-1:0]    thr_ha,
  input  logic [DW-1:0]    thr_la,
  input  logic [DW-1:0]    thr_hw,
  input  logic [DW-1:0]    thr_lw,
  output logic [NKIND-1:0] viol
);
  always_comb begin
    viol        = '0;
    viol[K_HA]  = reading > thr_ha;
    viol[K_LA]  = reading < thr_la;
    viol[K_HW]  = reading > thr_hw;
    viol[K_LW]  = reading < thr_lw;
  end

  // R1/R2: with ordered limits a reading cannot be above and below at once
  always_comb begin
    if (thr_la <= thr_ha) begin
      a_r2_no_double_alarm: assert (!(viol[K_HA] && viol[K_LA]));
    end
  end
endmodule

// File: rtl/fic_sticky.sv
module fic_sticky #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] flag_o
);
  logic [W-1:0] flag_q;

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= (flag_q & ~{W{clr_i}}) | set_i;
  end

  assign flag_o = flag_q;

  // R4: a set flag without a clear stays set
  a_r4_sticky_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(clr_i)) |-> ((($past(flag_q)) & ~flag_q) == '0));

  // R6: an active cause always leaves the flag set, even across a clear
  a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((($past(set_i)) & ~flag_q) == '0));
endmodule

// File: rtl/fic_regs.sv
module fic_regs
  import fic_pkg::*;
#(
  parameter int DW       = 16,
  parameter int AW       = 8,
  parameter int NUM_ATTR = 5,
  parameter int NGRP     = 7,
  parameter int GRP_W    = 4,
  localparam int NTHR    = NUM_ATTR * NKIND
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [AW-1:0]         addr,
  input  logic [DW-1:0]         wdata,
  output logic [NTHR*DW-1:0]    thr_flat,
  output logic [NGRP*GRP_W-1:0] mask_flat,
  output logic [DW-1:0]         cfg_rdata,
  output logic                  cfg_hit
);
  logic [DW-1:0]    thr_q  [NTHR];
  logic [GRP_W-1:0] mask_q [NGRP];

  for (genvar i = 0; i < NTHR; i++) begin : g_thr
    localparam logic [DW-1:0] RST_VAL = is_high_kind(i % NKIND) ? '1 : '0;
    always_ff @(posedge clk) begin
      if (rst)                                     thr_q[i] <= RST_VAL;
      else if (wr_en && addr == AW'(THR_BASE + i)) thr_q[i] <= wdata;
    end
    assign thr_flat[i*DW +: DW] = thr_q[i];
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_mask
    always_ff @(posedge clk) begin
      if (rst)                                      mask_q[g] <= '0;
      else if (wr_en && addr == AW'(MASK_BASE + g)) mask_q[g] <= wdata[GRP_W-1:0];
    end
    assign mask_flat[g*GRP_W +: GRP_W] = mask_q[g];
  end

  always_comb begin
    cfg_rdata = '0;
    cfg_hit   = 1'b0;
    for (int i = 0; i < NTHR; i++) begin
      if (addr == AW'(THR_BASE + i)) begin
        cfg_rdata = thr_q[i];
        cfg_hit   = 1'b1;
      end
    end
    for (int g = 0; g < NGRP; g++) begin
      if (addr == AW'(MASK_BASE + g)) begin
        cfg_rdata[GRP_W-1:0] = mask_q[g];
        cfg_hit              = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fic_ctrl.sv
module fic_ctrl
  import fic_pkg::*;
#(
  parameter int NUM_ATTR = 5,
  parameter int NUM_CH   = 4,
  parameter int DW       = 16,
  parameter int AW       = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_ATTR*DW-1:0] attr_rd,
  input  logic [NUM_CH-1:0]      ch_los,
  input  logic [NUM_CH-1:0]      ch_fault,
  input  logic [AW-1:0]          reg_addr,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [DW-1:0]          reg_wdata,
  output logic [DW-1:0]          reg_rdata,
  output logic                   int_n
);
  localparam int NGRP  = GRP_ATTR0 + NUM_ATTR;
  localparam int GRP_W = max2(NUM_CH, NKIND);
  localparam int NTHR  = NUM_ATTR * NKIND;

  logic [NTHR*DW-1:0]    thr_flat;
  logic [NGRP*GRP_W-1:0] mask_flat;
  logic [DW-1:0]         cfg_rdata;
  logic                  cfg_hit;
  logic [NKIND-1:0]      viol  [NUM_ATTR];
  logic [GRP_W-1:0]      cond  [NGRP];
  logic [GRP_W-1:0]      flags [NGRP];
  logic [NGRP-1:0]       clr;
  logic                  pend;
  logic [DW-1:0]         rd_mux;
  logic [DW-1:0]         rdata_q;
  logic                  int_n_q;

  fic_regs #(
    .DW(DW), .AW(AW), .NUM_ATTR(NUM_ATTR), .NGRP(NGRP), .GRP_W(GRP_W)
  ) regs_i (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .thr_flat(thr_flat), .mask_flat(mask_flat),
    .cfg_rdata(cfg_rdata), .cfg_hit(cfg_hit)
  );

  for (genvar a = 0; a < NUM_ATTR; a++) begin : g_cmp
    localparam int TB = a * NKIND;
    fic_thr_cmp #(.DW(DW)) cmp_i (
      .reading(attr_rd[a*DW +: DW]),
      .thr_ha (thr_flat[(TB + K_HA)*DW +: DW]),
      .thr_la (thr_flat[(TB + K_LA)*DW +: DW]),
      .thr_hw (thr_flat[(TB + K_HW)*DW +: DW]),
      .thr_lw (thr_flat[(TB + K_LW)*DW +: DW]),
      .viol   (viol[a])
    );
  end

  always_comb begin
    for (int g = 0; g < NGRP; g++) cond[g] = '0;
    cond[GRP_LOS][NUM_CH-1:0] = ch_los;
    cond[GRP_FLT][NUM_CH-1:0] = ch_fault;
    for (int a = 0; a < NUM_ATTR; a++) cond[GRP_ATTR0 + a][NKIND-1:0] = viol[a];
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_flag
    assign clr[g] = reg_rd && (reg_addr == AW'(FLAG_BASE + g));
    fic_sticky #(.W(GRP_W)) sticky_i (
      .clk(clk), .rst(rst), .set_i(cond[g]), .clr_i(clr[g]), .flag_o(flags[g])
    );
  end

  always_comb begin
    rd_mux = cfg_hit ? cfg_rdata : '0;
    for (int g = 0; g < NGRP; g++) begin
      if (reg_addr == AW'(FLAG_BASE + g)) rd_mux[GRP_W-1:0] = flags[g];
    end
  end

  always_comb begin
    pend = 1'b0;
    for (int g = 0; g < NGRP; g++) pend |= |(flags[g] & ~mask_flat[g*GRP_W +: GRP_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      int_n_q <= 1'b1;
    end else begin
      if (reg_rd) rdata_q <= rd_mux;
      int_n_q <= ~pend;
    end
  end

  assign reg_rdata = rdata_q;
  assign int_n     = int_n_q;

  // R7: a pending unmasked flag drives the line low on the next cycle
  a_r7_int_assert: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pend)) |-> !int_n);

  // R8: once nothing is pending the line releases on the next cycle
  a_r8_int_release: assert property (@(posedge clk) disable iff (rst)
    (!int_n && !pend) |=> int_n);

  // R5: read data only moves on a read strobe
  a_r5_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(reg_rd)) |-> $stable(reg_rdata));
endmodule

// File: tb/fic_ctrl_tb_top.sv
module fic_ctrl_tb_top;
  localparam int NA = 5;
  localparam int NC = 4;
  localparam int DW = 16;
  localparam int AW = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NA*DW-1:0] attr_rd;
  logic [NC-1:0]    ch_los = '0;
  logic [NC-1:0]    ch_fault = '0;
  logic [AW-1:0]    reg_addr = '0;
  logic             reg_wr = 1'b0;
  logic             reg_rd = 1'b0;
  logic [DW-1:0]    reg_wdata = '0;
  logic [DW-1:0]    reg_rdata;
  logic             int_n;

  int n_cmp  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  fic_ctrl #(.NUM_ATTR(NA), .NUM_CH(NC), .DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .attr_rd(attr_rd), .ch_los(ch_los), .ch_fault(ch_fault),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .int_n(int_n)
  );

  typedef struct packed {
    logic [2:0]  attr;
    logic [15:0] val;
    logic [3:0]  exp;
  } vec_t;

  // thresholds for every attribute: HA 1000, LA 100, HW 800, LW 200
  // flag bits: 0 HA, 1 LA, 2 HW, 3 LW
  localparam int NVEC = 10;
  localparam vec_t VEC [NVEC] = '{
    '{3'd0, 16'd1001,  4'b0101},
    '{3'd1, 16'd1000,  4'b0100},
    '{3'd2, 16'd801,   4'b0100},
    '{3'd3, 16'd800,   4'b0000},
    '{3'd4, 16'd199,   4'b1000},
    '{3'd0, 16'd99,    4'b1010},
    '{3'd1, 16'd100,   4'b1000},
    '{3'd2, 16'd200,   4'b0000},
    '{3'd3, 16'd65535, 4'b0101},
    '{3'd4, 16'd0,     4'b1010}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    reg_addr = a; reg_rd = 1'b1;
    tick();
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic set_all_mid();
    for (int a = 0; a < NA; a++) attr_rd[a*DW +: DW] = 16'd500;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    set_all_mid();
    repeat (3) tick();
    rst = 1'b0;
    tick();

    // R10 reset state
    chk("R10 int_n after reset", 16'(int_n), 16'd1);
    rd(8'h20, d); chk("R10 high alarm threshold reset", d, 16'hFFFF);
    rd(8'h22, d); chk("R10 high warning threshold reset", d, 16'hFFFF);
    rd(8'h21, d); chk("R10 low alarm threshold reset", d, 16'h0000);
    rd(8'h10, d); chk("R10 mask reset", d, 16'h0000);
    rd(8'h02, d); chk("R10 attribute flags reset", d, 16'h0000);

    // R11 program thresholds
    for (int a = 0; a < NA; a++) begin
      wr(8'(32 + 4*a + 0), 16'd1000);
      wr(8'(32 + 4*a + 1), 16'd100);
      wr(8'(32 + 4*a + 2), 16'd800);
      wr(8'(32 + 4*a + 3), 16'd200);
    end
    rd(8'h26, d); chk("R11 threshold readback", d, 16'd800);
    rd(8'h26, d); chk("R11 threshold second read unchanged", d, 16'd800);

    // R1 R2 R4 R5 R7 R8 table walk
    for (int i = 0; i < NVEC; i++) begin
      attr_rd[VEC[i].attr*DW +: DW] = VEC[i].val;
      tick();
      set_all_mid();
      tick();
      chk($sformatf("R7 int_n vec %0d", i), 16'(int_n), 16'(VEC[i].exp == 4'b0000));
      rd(8'(2 + VEC[i].attr), d);
      chk($sformatf("R1 R2 R4 flags vec %0d", i), d, 16'(VEC[i].exp));
      rd(8'(2 + VEC[i].attr), d);
      chk($sformatf("R5 cleared after read vec %0d", i), d, 16'h0000);
      chk($sformatf("R8 int_n released vec %0d", i), 16'(int_n), 16'd1);
    end

    // R3 R6 hold los[1] across reads
    ch_los = 4'b0010;
    tick(); tick();
    chk("R7 int_n low on loss of signal", 16'(int_n), 16'd0);
    rd(8'h00, d); chk("R3 loss flag channel 1", d, 16'h0002);
    rd(8'h00, d); chk("R6 set wins over clear", d, 16'h0002);
    ch_los = 4'b0000;
    rd(8'h00, d); chk("R4 flag still set after cause gone", d, 16'h0002);
    rd(8'h00, d); chk("R5 loss flag cleared", d, 16'h0000);
    chk("R8 int_n high after clear", 16'(int_n), 16'd1);

    // R3 R5 fault read leaves loss flags alone
    ch_fault = 4'b1000; ch_los = 4'b0001;
    tick();
    ch_fault = 4'b0000; ch_los = 4'b0000;
    tick();
    rd(8'h01, d); chk("R3 fault flag channel 3", d, 16'h0008);
    tick();
    chk("R5 int_n still low, loss flag pending", 16'(int_n), 16'd0);
    rd(8'h00, d); chk("R5 loss flag survived fault read", d, 16'h0001);
    tick();
    chk("R8 int_n high after both cleared", 16'(int_n), 16'd1);

    // R9 mask
    wr(8'h10, 16'h0004);
    ch_los = 4'b0100;
    tick();
    ch_los = 4'b0000;
    tick(); tick();
    chk("R9 masked flag keeps int_n high", 16'(int_n), 16'd1);
    wr(8'h10, 16'h0000);
    tick();
    chk("R7 unmask raises interrupt", 16'(int_n), 16'd0);
    wr(8'h10, 16'h0004);
    tick();
    chk("R8 re-mask releases interrupt", 16'(int_n), 16'd1);
    rd(8'h10, d); chk("R11 mask readback", d, 16'h0004);
    rd(8'h00, d); chk("R9 masked flag still readable", d, 16'h0004);
    rd(8'h00, d); chk("R5 masked flag cleared", d, 16'h0000);

    finish_run();
  end
endmodule